// File: doc/BRIEF.md
# DMA Instruction Stream Walker

This block follows a stream of 32-bit DMA program words and labels each word as it goes past. A program is a string of variable-length instructions. The first word of each instruction carries a 4-bit opcode, a 16-bit flag field and a 12-bit byte count. Depending on the opcode, that first word is followed by zero to three argument words. The walker works out where each instruction starts. For a first word it reports the opcode and its fields. For an argument word it reports only its position within the instruction, so an argument whose top nibble happens to look like an opcode is never decoded as one. The block does not execute anything.

Words come in on a valid/ready port, and one decode record per word goes out on a second valid/ready port. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. A record is handed over on an edge where `out_valid` and `out_ready` are both high. The output has a single holding register. The walker therefore accepts a new word only when that register is empty or is being emptied on the same edge. While the consumer holds `out_ready` low, the record stays frozen and the input is stalled. A plain running total of instruction heads is also provided.

Top module: `dma_prog_walker`

## Requirements
- R1: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its record appears with `out_valid` high one cycle after that edge. `in_ready` is high whenever the output register is empty or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every record output holds its value.
- R3: For a head word, `out_opcode` equals word bits 31:28 and `out_count` equals word bits 11:0. `out_word` always carries the raw word.
- R4: For a head word, `out_flags[i]` equals word bit 12+i. This places resync at index 3, the two counter controls at indices 4 and 5, IRQ1 at 12, IRQ2 at 13, end-of-line at 14 and start-of-line at 15.
- R5: `out_known` is high for exactly ten opcodes: 1 write, 2 skip, 5 write-with-count, 7 jump, 8 sync, 9 read, A read-with-count, B masked write to RAM, C masked write with count, D register-clear write. The codes 0, 3, 4, 6, E and F give `out_known` low.
- R6: Instruction length in words is 2 for write and jump, 3 for the two masked writes (B, C), 4 for the register-clear write (D), and 1 for every other known opcode.
- R7: An argument word gives `out_head` low and `out_arg_idx` equal to its position after the head, counting from 1. It also gives `out_opcode`, `out_flags`, `out_count` and `out_known` all zero. A head word gives `out_head` high and `out_arg_idx` zero.
- R8: An unknown opcode is consumed as a 1-word instruction, so the next word is a head. Its flags and count are still reported.
- R9: `instr_total` increases by one for each head word accepted. The new value is visible in the same cycle as that word's record, and argument words leave it unchanged.
- R10: Reset clears `out_valid` and `instr_total`. The first word accepted after reset is a head, even if reset arrived in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Walker can take a word |
| in_word | input | 32 | Program word |
| out_valid | output | 1 | Decode record present |
| out_ready | input | 1 | Consumer takes the record |
| out_word | output | 32 | Raw word of this record |
| out_head | output | 1 | Word starts an instruction |
| out_opcode | output | 4 | Opcode of a head word |
| out_known | output | 1 | Opcode is one of the ten defined |
| out_flags | output | 16 | Flag field of a head word |
| out_count | output | 12 | Byte count of a head word |
| out_arg_idx | output | 2 | Argument position, 0 for a head |
| instr_total | output | CNT_W | Instruction heads seen since reset |

## Verification
Every record and its matching `instr_total` value are due exactly one cycle after the edge that accepts the word. The bench drives a word at one falling edge and reads the result at the next falling edge, which puts a single register stage between stimulus and sample. Under back-pressure, the frozen record and the low `in_ready` are sampled on each stalled cycle. The next record is expected one cycle after `out_ready` returns high. After a reset in the middle of an instruction, `out_valid` and `instr_total` are read low before any new word is driven, and the first word after reset is then checked one cycle after it is accepted.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W   = 32;
  localparam int OPC_W    = 4;
  localparam int FLAG_W   = 16;
  localparam int BYTES_W  = 12;
  localparam int IDX_W    = 2;
  localparam int OPC_LSB  = WORD_W - OPC_W;
  localparam int FLAG_LSB = BYTES_W;
  localparam int N_OPC    = 1 << OPC_W;

  localparam logic [OPC_W-1:0] OPC_WR     = 4'h1;
  localparam logic [OPC_W-1:0] OPC_SKIP   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_WRC    = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JMP    = 4'h7;
  localparam logic [OPC_W-1:0] OPC_SYNC   = 4'h8;
  localparam logic [OPC_W-1:0] OPC_RD     = 4'h9;
  localparam logic [OPC_W-1:0] OPC_RDC    = 4'hA;
  localparam logic [OPC_W-1:0] OPC_WRM    = 4'hB;
  localparam logic [OPC_W-1:0] OPC_WRCM   = 4'hC;
  localparam logic [OPC_W-1:0] OPC_WRCR   = 4'hD;

  typedef struct packed {
    logic [WORD_W-1:0]  word;
    logic               head;
    logic [OPC_W-1:0]   opc;
    logic               known;
    logic [FLAG_W-1:0]  flags;
    logic [BYTES_W-1:0] bytes;
    logic [IDX_W-1:0]   arg_idx;
  } rec_t;

  function automatic logic opc_known(input logic [OPC_W-1:0] c);
    case (c)
      OPC_WR, OPC_SKIP, OPC_WRC, OPC_JMP, OPC_SYNC,
      OPC_RD, OPC_RDC, OPC_WRM, OPC_WRCM, OPC_WRCR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] opc_args(input logic [OPC_W-1:0] c);
    case (c)
      OPC_WR, OPC_JMP:   return 2'd1;
      OPC_WRM, OPC_WRCM: return 2'd2;
      OPC_WRCR:          return 2'd3;
      default:           return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dmaw_op_table.sv
module dmaw_op_table
  import dmaw_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic             known,
  output logic [IDX_W-1:0] args
);
  logic [N_OPC-1:0] known_tab;
  logic [IDX_W-1:0] args_tab [N_OPC];

  for (genvar g = 0; g < N_OPC; g++) begin : g_code
    assign known_tab[g] = opc_known(OPC_W'(g));
    assign args_tab[g]  = opc_args(OPC_W'(g));
  end

  assign known = known_tab[opc];
  assign args  = args_tab[opc];
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
  import dmaw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] head_args,
  output logic             at_head,
  output logic [IDX_W-1:0] arg_idx
);
  logic [IDX_W-1:0] remain_q;
  logic [IDX_W-1:0] next_idx_q;

  assign at_head = (remain_q == '0);
  assign arg_idx = at_head ? '0 : next_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q   <= '0;
      next_idx_q <= '0;
    end else if (adv) begin
      if (at_head) begin
        remain_q   <= head_args;
        next_idx_q <= IDX_W'(1);
      end else begin
        remain_q   <= remain_q - 1'b1;
        next_idx_q <= next_idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmaw_out_reg.sv
module dmaw_out_reg
  import dmaw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rec_t rec_in,
  input  logic take,
  output logic room,
  output logic full,
  output rec_t rec_q
);
  assign room = !full || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      rec_q <= '0;
    end else if (room) begin
      full <= load;
      if (load) rec_q <= rec_in;
    end
  end
endmodule

// File: rtl/dmaw_instr_ctr.sv
module dmaw_instr_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    total <= '0;
    else if (bump) total <= total + 1'b1;
  end
endmodule

// File: rtl/dma_prog_walker.sv
module dma_prog_walker
  import dmaw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_head,
  output logic [OPC_W-1:0]   out_opcode,
  output logic               out_known,
  output logic [FLAG_W-1:0]  out_flags,
  output logic [BYTES_W-1:0] out_count,
  output logic [IDX_W-1:0]   out_arg_idx,
  output logic [CNT_W-1:0]   instr_total
);
  logic             fire;
  logic             at_head;
  logic             opc_ok;
  logic [IDX_W-1:0] opc_nargs;
  logic [IDX_W-1:0] cur_idx;
  logic [OPC_W-1:0] in_opc;
  rec_t             rec_d;
  rec_t             rec_q;

  assign in_opc = in_word[WORD_W-1:OPC_LSB];
  assign fire   = in_valid && in_ready;

  dmaw_op_table u_tab (
    .opc   (in_opc),
    .known (opc_ok),
    .args  (opc_nargs)
  );

  dmaw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (fire),
    .head_args (opc_nargs),
    .at_head   (at_head),
    .arg_idx   (cur_idx)
  );

  always_comb begin
    rec_d         = '0;
    rec_d.word    = in_word;
    rec_d.head    = at_head;
    rec_d.arg_idx = cur_idx;
    if (at_head) begin
      rec_d.opc   = in_opc;
      rec_d.known = opc_ok;
      rec_d.flags = in_word[FLAG_LSB +: FLAG_W];
      rec_d.bytes = in_word[BYTES_W-1:0];
    end
  end

  dmaw_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .rec_in (rec_d),
    .take   (out_ready),
    .room   (in_ready),
    .full   (out_valid),
    .rec_q  (rec_q)
  );

  dmaw_instr_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (fire && at_head),
    .total (instr_total)
  );

  assign out_word    = rec_q.word;
  assign out_head    = rec_q.head;
  assign out_opcode  = rec_q.opc;
  assign out_known   = rec_q.known;
  assign out_flags   = rec_q.flags;
  assign out_count   = rec_q.bytes;
  assign out_arg_idx = rec_q.arg_idx;
endmodule

// File: rtl/dma_prog_walker_chk.sv
module dma_prog_walker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_word,
  input logic             out_head,
  input logic [3:0]       out_opcode,
  input logic             out_known,
  input logic [15:0]      out_flags,
  input logic [11:0]      out_count,
  input logic [1:0]       out_arg_idx,
  input logic [CNT_W-1:0] instr_total
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_head)
      && $stable(out_arg_idx) && $stable(out_flags) && $stable(out_count));

  assert_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && out_known |->
      (out_opcode inside {4'h1, 4'h2, 4'h5, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD}));

  assert_head_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head |-> out_arg_idx == 2'd0);

  assert_arg_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_head |-> out_arg_idx != 2'd0 && out_opcode == 4'h0
      && !out_known && out_flags == '0 && out_count == '0);

  assert_total_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (instr_total == $past(instr_total)) || (instr_total == $past(instr_total) + 1'b1));
endmodule

bind dma_prog_walker dma_prog_walker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word),
  .out_head    (out_head),
  .out_opcode  (out_opcode),
  .out_known   (out_known),
  .out_flags   (out_flags),
  .out_count   (out_count),
  .out_arg_idx (out_arg_idx),
  .instr_total (instr_total)
);

// File: tb/dma_prog_walker_bench.sv
module dma_prog_walker_bench;
  localparam int CNT_W = 16;
  localparam int NV    = 22;

  // {word, expected argument index}; index 0 means a head word
  localparam logic [33:0] VEC [NV] = '{
    {32'h1C00_0100, 2'd0}, {32'h0000_1000, 2'd1},
    {32'h8000_8000, 2'd0},
    {32'hB000_0004, 2'd0}, {32'hFFFF_FFFF, 2'd1}, {32'h1234_5678, 2'd2},
    {32'hD000_0010, 2'd0}, {32'h8000_0000, 2'd1}, {32'h0000_0001, 2'd2}, {32'hD000_0000, 2'd3},
    {32'h3000_0ABC, 2'd0},
    {32'h7000_0000, 2'd0}, {32'h9000_0000, 2'd1},
    {32'hC300_0008, 2'd0}, {32'h1000_0000, 2'd1}, {32'h7000_0000, 2'd2},
    {32'h5000_0001, 2'd0},
    {32'hF000_0FFF, 2'd0},
    {32'h2000_0000, 2'd0},
    {32'hA000_0000, 2'd0},
    {32'h9000_0000, 2'd0},
    {32'h0000_0000, 2'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_word = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [31:0]      out_word;
  logic             out_head;
  logic [3:0]       out_opcode;
  logic             out_known;
  logic [15:0]      out_flags;
  logic [11:0]      out_count;
  logic [1:0]       out_arg_idx;
  logic [CNT_W-1:0] instr_total;

  int n_run  = 0;
  int n_fail = 0;
  int heads  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dma_prog_walker #(.CNT_W(CNT_W)) u_dma_prog_walker (.*);

  function automatic bit ref_known(input logic [3:0] c);
    return c inside {4'h1, 4'h2, 4'h5, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_rec(input string req, input logic [31:0] w, input logic [1:0] idx);
    bit h;
    h = (idx == 2'd0);
    check({req, " R1 valid"}, 64'(out_valid), 64'd1);
    check({req, " R3 word"}, 64'(out_word), 64'(w));
    check({req, " R7 head"}, 64'(out_head), 64'(h));
    check({req, " R7 idx"}, 64'(out_arg_idx), 64'(idx));
    check({req, " R3 opcode"}, 64'(out_opcode), h ? 64'(w[31:28]) : 64'd0);
    check({req, " R5 known"}, 64'(out_known), h ? 64'(ref_known(w[31:28])) : 64'd0);
    check({req, " R4 flags"}, 64'(out_flags), h ? 64'(w[27:12]) : 64'd0);
    check({req, " R3 count"}, 64'(out_count), h ? 64'(w[11:0]) : 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset total", 64'(instr_total), 64'd0);
    check("R1 ready when empty", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // table pass: one word per cycle, R6 lengths and R8 unknown codes via indices
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_word  = VEC[i][33:2];
      @(negedge clk);
      if (VEC[i][1:0] == 2'd0) heads++;
      check_rec($sformatf("R6 vec%0d", i), VEC[i][33:2], VEC[i][1:0]);
      check("R9 total", 64'(instr_total), 64'(heads));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 drained", 64'(out_valid), 64'd0);
    check("R9 total held", 64'(instr_total), 64'(heads));

    // back-pressure
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = 32'h1000_0020;
    @(negedge clk);
    check_rec("R2 first", 32'h1000_0020, 2'd0);
    in_word = 32'h0000_ABCD;
    for (int k = 0; k < 3; k++) begin
      check("R2 stall ready", 64'(in_ready), 64'd0);
      @(negedge clk);
      check_rec("R2 held", 32'h1000_0020, 2'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_rec("R2 release", 32'h0000_ABCD, 2'd1);
    in_valid = 1'b0;
    @(negedge clk);

    // reset in the middle of a register-clear instruction
    in_valid = 1'b1;
    in_word  = 32'hD000_0000;
    @(negedge clk);
    check_rec("R6 writecr head", 32'hD000_0000, 2'd0);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R10 mid valid", 64'(out_valid), 64'd0);
    check("R10 mid total", 64'(instr_total), 64'd0);
    rst_n    = 1'b1;
    in_valid = 1'b1;
    in_word  = 32'h1000_0005;
    @(negedge clk);
    check_rec("R10 head after reset", 32'h1000_0005, 2'd0);
    check("R10 R9 total", 64'(instr_total), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule